// File: doc/BRIEF.md
# Perturb-and-Observe Maximum Power Point Tracker

This block steers a boost converter so that a photovoltaic array operates near its maximum power point. Each time it receives a tracking tick, it captures one array voltage sample and one array current sample, both unsigned. It multiplies them to get the present power. It then compares this power and the voltage with the values it stored on the previous iteration. From the signs of the two changes it decides whether the array voltage should go up or down, and it moves a duty-cycle register by a programmable step in the matching direction. A higher duty cycle lowers the array voltage, so raising the voltage means lowering the duty, and the other way round.

The controller is a small state machine with three named states. ST_IDLE waits for a tick and latches the samples (transition IDLE->MULT on a tick, IDLE->IDLE otherwise). ST_MULT registers the power product (MULT->DECIDE, unconditional). ST_DECIDE forms the signed differences, applies the decision and the clamp, and overwrites the history (DECIDE->IDLE, unconditional). The duty word stays between two configurable limits. It is computed one bit wider than the register, so it saturates at those limits and never wraps. A direction flag reports whether the last real move raised the array voltage.

Top module: `pno_tracker`

## Requirements
- R1: A synchronous reset sets the duty to 512 (half of full scale for the default 10-bit width), clears the direction flag to 0, and clears the stored voltage and power. The first tick after reset therefore sees a power change equal to V·I and a voltage change equal to V.
- R2: Power is the full-width product V·I of the two 12-bit samples (up to 4095·4095 = 16769025). The power change against the stored value is taken as a signed difference with no overflow.
- R3: Let "voltage rose" mean V(k) − V(k−1) > 0; a zero voltage change counts as not rose. The decision is: power rose and voltage rose, raise the voltage (duty down, flag 1). Power rose and voltage not rose, lower the voltage (duty up, flag 0). Power fell and voltage rose, lower the voltage (duty up, flag 0). Power fell and voltage not rose, raise the voltage (duty down, flag 1).
- R4: A move changes the duty by exactly `duty_step` unless the clamp of R6 limits it.
- R5: When the power change is exactly zero, both the duty and the direction flag keep their values.
- R6: A downward move gives max(duty − step, `duty_lo`). An upward move gives min(duty + step, `duty_hi`). The result never wraps.
- R7: Every iteration, including one with zero power change, overwrites the stored voltage and power with the current samples.
- R8: A tick is taken only in the idle state. Its result appears on `duty_out` and `vdir_up` just after the third rising edge, counting the edge that accepts the tick as the first. A tick held high during the two busy cycles starts no further iteration.
- R9: While no tick is accepted, `duty_out` and `vdir_up` hold their values whatever the sample inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Request for one tracking iteration |
| volt_smp | input | 12 | Array voltage sample, unsigned |
| curr_smp | input | 12 | Array current sample, unsigned |
| duty_step | input | 10 | Perturbation step added to or subtracted from the duty |
| duty_lo | input | 10 | Lowest allowed duty |
| duty_hi | input | 10 | Highest allowed duty |
| duty_out | output | 10 | Duty-cycle word for the boost converter |
| vdir_up | output | 1 | 1 when the last move raised the array voltage |

## Verification
The driver raises the tick on a falling edge. The accepting rising edge follows half a cycle later, the product is registered on the next edge, and the decision lands on the third. The driver therefore stamps each expected duty and flag as due three cycles after the tick was raised. The monitor compares the outputs only on the falling edge where the stamp matches the cycle count, and it flags any expectation still waiting once its cycle has passed. The hold checks for a held tick and for an idle period push a second expectation further out, stamped at the cycle where an unwanted change would already be visible.

// File: rtl/pno_pkg.sv
package pno_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MULT   = 2'd1,
        ST_DECIDE = 2'd2
    } pno_state_e;

    // MV_UP raises the duty (lowers array voltage), MV_DOWN lowers it
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2
    } duty_move_e;

endpackage

// File: rtl/pno_power_mult.sv
module pno_power_mult #(
    parameter int SAMPLE_W = 12,
    localparam int PWR_W   = 2 * SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] mul_a,
    input  logic [SAMPLE_W-1:0] mul_b,
    output logic [PWR_W-1:0]    prod_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else if (load) begin
            prod_q <= mul_a * mul_b;
        end
    end

endmodule

// File: rtl/pno_decide.sv
module pno_decide
    import pno_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    localparam int PWR_W   = 2 * SAMPLE_W
) (
    input  logic [PWR_W-1:0]    pwr_now,
    input  logic [PWR_W-1:0]    pwr_prev,
    input  logic [SAMPLE_W-1:0] v_now,
    input  logic [SAMPLE_W-1:0] v_prev,
    output duty_move_e          move,
    output logic                raise_v
);

    logic signed [PWR_W:0]    dp;
    logic signed [SAMPLE_W:0] dv;
    logic                     p_rise;
    logic                     p_fall;
    logic                     v_rose;

    assign dp     = $signed({1'b0, pwr_now}) - $signed({1'b0, pwr_prev});
    assign dv     = $signed({1'b0, v_now}) - $signed({1'b0, v_prev});
    assign p_fall = dp[PWR_W];
    assign p_rise = !dp[PWR_W] && (dp != '0);
    assign v_rose = !dv[SAMPLE_W] && (dv != '0);

    // Same-sign changes keep climbing in voltage; opposite signs back off
    assign raise_v = (p_rise && v_rose) || (p_fall && !v_rose);

    always_comb begin
        if (!p_rise && !p_fall) begin
            move = MV_HOLD;
        end else if (raise_v) begin
            move = MV_DOWN;
        end else begin
            move = MV_UP;
        end
    end

endmodule

// File: rtl/pno_duty_clamp.sv
module pno_duty_clamp
    import pno_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input  logic [DUTY_W-1:0] duty_cur,
    input  logic [DUTY_W-1:0] step,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    input  duty_move_e        move,
    output logic [DUTY_W-1:0] duty_nxt
);

    logic [DUTY_W:0] sum_up;
    logic [DUTY_W:0] floor_dn;

    assign sum_up   = {1'b0, duty_cur} + {1'b0, step};
    assign floor_dn = {1'b0, lim_lo} + {1'b0, step};

    always_comb begin
        unique case (move)
            MV_UP: begin
                if (sum_up > {1'b0, lim_hi}) begin
                    duty_nxt = lim_hi;
                end else begin
                    duty_nxt = sum_up[DUTY_W-1:0];
                end
            end
            MV_DOWN: begin
                if ({1'b0, duty_cur} < floor_dn) begin
                    duty_nxt = lim_lo;
                end else begin
                    duty_nxt = duty_cur - step;
                end
            end
            default: duty_nxt = duty_cur;
        endcase
    end

endmodule

// File: rtl/pno_tracker.sv
module pno_tracker
    import pno_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int DUTY_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic [SAMPLE_W-1:0] volt_smp,
    input  logic [SAMPLE_W-1:0] curr_smp,
    input  logic [DUTY_W-1:0]   duty_step,
    input  logic [DUTY_W-1:0]   duty_lo,
    input  logic [DUTY_W-1:0]   duty_hi,
    output logic [DUTY_W-1:0]   duty_out,
    output logic                vdir_up
);

    localparam int PWR_W = 2 * SAMPLE_W;
    localparam logic [DUTY_W-1:0] DUTY_MID = {1'b1, {(DUTY_W-1){1'b0}}};

    pno_state_e          state;
    pno_state_e          state_nx;
    logic [SAMPLE_W-1:0] v_cur;
    logic [SAMPLE_W-1:0] i_cur;
    logic [SAMPLE_W-1:0] v_prev;
    logic [PWR_W-1:0]    p_prev;
    logic [PWR_W-1:0]    pwr_q;
    duty_move_e          move;
    logic                raise_v;
    logic [DUTY_W-1:0]   duty_nx;

    pno_power_mult #(.SAMPLE_W(SAMPLE_W)) mult_i (
        .clk    (clk),
        .rst    (rst),
        .load   (state == ST_MULT),
        .mul_a  (v_cur),
        .mul_b  (i_cur),
        .prod_q (pwr_q)
    );

    pno_decide #(.SAMPLE_W(SAMPLE_W)) decide_i (
        .pwr_now  (pwr_q),
        .pwr_prev (p_prev),
        .v_now    (v_cur),
        .v_prev   (v_prev),
        .move     (move),
        .raise_v  (raise_v)
    );

    pno_duty_clamp #(.DUTY_W(DUTY_W)) clamp_i (
        .duty_cur (duty_out),
        .step     (duty_step),
        .lim_lo   (duty_lo),
        .lim_hi   (duty_hi),
        .move     (move),
        .duty_nxt (duty_nx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = tick_en ? ST_MULT : ST_IDLE;
            ST_MULT:   state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs and history
    always_ff @(posedge clk) begin
        if (rst) begin
            v_cur    <= '0;
            i_cur    <= '0;
            v_prev   <= '0;
            p_prev   <= '0;
            duty_out <= DUTY_MID;
            vdir_up  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tick_en) begin
                        v_cur <= volt_smp;
                        i_cur <= curr_smp;
                    end
                end
                ST_DECIDE: begin
                    duty_out <= duty_nx;
                    if (move != MV_HOLD) begin
                        vdir_up <= raise_v;
                    end
                    v_prev <= v_cur;
                    p_prev <= pwr_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pno_tracker_chk.sv
module pno_tracker_chk
    import pno_pkg::*;
#(
    parameter int DUTY_W = 10,
    parameter int PWR_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input pno_state_e        state,
    input logic [PWR_W-1:0]  pwr_q,
    input logic [PWR_W-1:0]  p_prev,
    input logic [DUTY_W-1:0] duty_out,
    input logic              vdir_up,
    input logic [DUTY_W-1:0] duty_step,
    input logic [DUTY_W-1:0] duty_lo,
    input logic [DUTY_W-1:0] duty_hi
);

    localparam logic [DUTY_W-1:0] MID = {1'b1, {(DUTY_W-1){1'b0}}};

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RESET_MID: assert (duty_out == MID && !vdir_up && p_prev == '0)
                else $error("reset state wrong"); // R1
        end
    end

    AST_NO_MOVE_OUTSIDE_DECIDE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_DECIDE) |=> $stable(duty_out) && $stable(vdir_up)); // R9

    AST_ZERO_DP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE && pwr_q == p_prev) |=> $stable(duty_out) && $stable(vdir_up)); // R5

    AST_DUTY_IN_LIMITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE && pwr_q != p_prev && duty_lo <= duty_hi)
        |=> (duty_out >= $past(duty_lo) && duty_out <= $past(duty_hi))); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE) |=>
        (((duty_out >= $past(duty_out)) ? (duty_out - $past(duty_out))
                                        : ($past(duty_out) - duty_out)) <= $past(duty_step))); // R4

    AST_MULT_TO_DECIDE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MULT) |=> (state == ST_DECIDE)); // R8

    AST_DECIDE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE) |=> (state == ST_IDLE)); // R8

    AST_HISTORY_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE) |=> (p_prev == $past(pwr_q))); // R7

endmodule

bind pno_tracker pno_tracker_chk #(.DUTY_W(DUTY_W), .PWR_W(PWR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .pwr_q     (pwr_q),
    .p_prev    (p_prev),
    .duty_out  (duty_out),
    .vdir_up   (vdir_up),
    .duty_step (duty_step),
    .duty_lo   (duty_lo),
    .duty_hi   (duty_hi)
);

// File: tb/pno_tracker_tb_top.sv
`timescale 1ns/1ps
module pno_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [11:0] volt_smp = '0;
    logic [11:0] curr_smp = '0;
    logic [9:0] duty_step = 10'd8;
    logic [9:0] duty_lo = 10'd100;
    logic [9:0] duty_hi = 10'd900;
    logic [9:0] duty_out;
    logic       vdir_up;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference state of the bench model
    int     m_duty = 512;
    bit     m_dir = 1'b0;
    longint m_p = 0;
    longint m_v = 0;

    // Scoreboard queues
    int    q_duty[$];
    bit    q_dir[$];
    int    q_due[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pno_tracker dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .volt_smp  (volt_smp),
        .curr_smp  (curr_smp),
        .duty_step (duty_step),
        .duty_lo   (duty_lo),
        .duty_hi   (duty_hi),
        .duty_out  (duty_out),
        .vdir_up   (vdir_up)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic push_exp(input string tag, input int due);
        q_duty.push_back(m_duty);
        q_dir.push_back(m_dir);
        q_due.push_back(due);
        q_tag.push_back(tag);
    endtask

    task automatic model_step(input int v, input int i);
        longint p, dp, dv;
        bit     raise;
        int     nd;
        p  = longint'(v) * longint'(i);
        dp = p - m_p;
        dv = longint'(v) - m_v;
        if (dp != 0) begin
            raise = ((dp > 0) == (dv > 0));
            if (raise) begin
                nd = m_duty - int'(duty_step);
                if (nd < int'(duty_lo)) nd = int'(duty_lo);
            end else begin
                nd = m_duty + int'(duty_step);
                if (nd > int'(duty_hi)) nd = int'(duty_hi);
            end
            m_duty = nd;
            m_dir  = raise;
        end
        m_p = p;
        m_v = longint'(v);
    endtask

    // Driver: one tick pulse, result due three cycles later
    task automatic do_tick(input int v, input int i, input string tag);
        @(negedge clk);
        volt_smp = 12'(v);
        curr_smp = 12'(i);
        tick_en  = 1'b1;
        model_step(v, i);
        push_exp(tag, cyc + 3);
        @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Driver: tick held through the busy cycles; only one iteration expected
    task automatic do_tick_held(input int v, input int i);
        @(negedge clk);
        volt_smp = 12'(v);
        curr_smp = 12'(i);
        tick_en  = 1'b1;
        model_step(v, i);
        push_exp("R8 held tick first result", cyc + 3);
        push_exp("R8 held tick no second iteration", cyc + 7);
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_duty = 512;
        m_dir  = 1'b0;
        m_p    = 0;
        m_v    = 0;
        check_val("R1 reset duty", int'(duty_out), 512);
        check_val("R1 reset dir", int'(vdir_up), 0);
    endtask

    // Monitor: compare exactly when each expectation falls due
    always @(negedge clk) begin
        if (q_due.size() > 0) begin
            if (q_due[0] == cyc) begin
                check_val({q_tag[0], " duty"}, int'(duty_out), q_duty[0]);
                check_val({q_tag[0], " dir"}, int'(vdir_up), int'(q_dir[0]));
                void'(q_duty.pop_front());
                void'(q_dir.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end else if (q_due[0] < cyc) begin
                n_vec++;
                n_bad++;
                $display("FAIL %s actual=missed expected=due at %0d", q_tag[0], q_due[0]);
                void'(q_duty.pop_front());
                void'(q_dir.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // First tick after reset: history is zero, so power and voltage both rose
        do_tick(1000, 1000, "R1 first tick uses cleared history");
        do_tick(1100, 950,  "R3 power up volt up");
        do_tick(1200, 800,  "R3 power down volt up");
        do_tick(1100, 880,  "R3 power up volt down");
        do_tick(1000, 900,  "R3 power down volt down");
        do_tick(900, 1000,  "R5 zero power change");
        do_tick(950, 1000,  "R7 history taken on zero-change tick");
        do_tick(950, 1100,  "R3 voltage unchanged counts as not rose");
        do_tick(4095, 4095, "R2 full scale product");
        do_tick(0, 0,       "R2 drop from full scale");
        do_tick(2000, 1000, "R4 plain step");

        // Idle: samples move but no tick is given
        @(negedge clk);
        volt_smp = 12'd3000;
        curr_smp = 12'd50;
        push_exp("R9 no tick no change", cyc + 10);
        repeat (11) @(negedge clk);

        do_tick_held(2100, 900);

        // Saturation at the upper limit with a large step
        duty_step = 10'd300;
        for (int k = 0; k < 5; k++) begin
            do_tick(1000 + 100 * k, 2000 - 300 * k, "R6 upper clamp");
        end
        check_val("R6 parked at upper limit", int'(duty_out), 900);

        // Saturation at the lower limit
        for (int k = 0; k < 6; k++) begin
            do_tick(3000 - 200 * k, 1000 - 100 * k, "R6 lower clamp");
        end
        check_val("R6 parked at lower limit", int'(duty_out), 100);

        duty_step = 10'd1;
        do_tick(1500, 1500, "R4 unit step");

        do_reset();
        do_tick(500, 500, "R1 first tick after second reset");

        repeat (4) @(negedge clk);
        check_val("R8 scoreboard drained", q_due.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule